// File: doc/BRIEF.md
# I/O Port Decoder with Legacy-Port NMI Trap

This block sits between a Z80-class CPU's I/O strobes and the peripherals of a small machine. It looks only at the low byte of the I/O address and produces chip selects for a console serial device, a cassette interface and the first disk slot. It returns either the selected device's read data, a fixed value, or the state of an 8-bit switch bank. Port pairs that belonged to an older sibling machine are not routed to any device. Touching one of them fires a fixed-width non-maskable-interrupt pulse, so that system software can catch code that was written for the older machine.

The block also holds an 8-bit general purpose output latch. Three bits of that latch, at positions set by parameters, act as ROM-enable, floppy-RAM write-protect and timer-interrupt-enable. From them the block derives a 2-bit low-memory view code and gates a periodic timer interrupt request. That request is held until the CPU side acknowledges it. The two top bits of the latch leave the block as expansion outputs.

Top module: `io_port_decoder`

## Requirements
- R1: Decoding uses only bits 7:0 of `io_addr`. The upper address bits never change a chip select or the read data.
- R2: A read of a port that no region claims returns 0xFF and asserts no chip select. The claimed ports are 0x78–0x7B, 0xE8–0xEF, 0xF0–0xF2, 0xF8–0xF9 and 0xFA–0xFB.
- R3: During a read or write, `con_cs` is high for 0xE8–0xEF, `cas_cs` for 0xF8–0xF9 and `dsk_cs` for 0x78–0x7B. At most one of them is high at a time. A read returns the selected device's data input.
- R4: A read or write of 0xF0, 0xF1, 0xFA or 0xFB drives `nmi_out` high from the next clock edge for exactly NMI_CYCLES cycles. A read of these ports returns 0x00.
- R5: A trap access made while the pulse is active restarts it, so `nmi_out` stays high for NMI_CYCLES cycles after the last trap access.
- R6: A write to 0xF2 loads the general purpose latch at the clock edge. A read of 0xF2 returns `sw_bank`. `exp_bits` always equals latch bits 7:6.
- R7: While latch bit TMR_EN_BIT (default 1) is set, `tmr_irq` is raised once every TICK_CYCLES clock cycles. It stays high until `tmr_ack` is sampled high.
- R8: While latch bit TMR_EN_BIT is clear, `tmr_irq` is never raised.
- R9: After reset the latch holds ROM-enable (bit ROM_EN_BIT, default 5) and timer-enable set and every other bit clear. `mem_view` is 1 and `nmi_out`, `tmr_irq` and `exp_bits` are 0.
- R10: `mem_view` depends on latch bit ROM_EN_BIT and latch bit WP_BIT (default 3, write-protect). It is 2 when ROM-enable is clear, 0 when ROM-enable and write-protect are both set, and 1 when ROM-enable is set and write-protect is clear. It is never 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | CPU I/O address (low byte decoded) |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| sw_bank | input | 8 | Configuration switch bank |
| con_rdata | input | 8 | Console device read data |
| cas_rdata | input | 8 | Cassette interface read data |
| dsk_rdata | input | 8 | Disk slot read data |
| tmr_ack | input | 1 | Clears the pending timer interrupt |
| con_cs | output | 1 | Console chip select |
| cas_cs | output | 1 | Cassette chip select |
| dsk_cs | output | 1 | Disk slot chip select |
| io_rdata | output | 8 | Read data to the CPU |
| nmi_out | output | 1 | Non-maskable interrupt pulse |
| tmr_irq | output | 1 | Timer interrupt request |
| mem_view | output | 2 | Low-memory view code |
| exp_bits | output | 2 | Latched expansion output bits |

## Verification
The properties assume that `io_rd` and `io_wr` are never high together and that each strobe lasts one clock per access. The NMI window check depends on this: it counts every cycle that holds a trap strobe as a fresh access. The stimulus drives at most one strobe per access, changes inputs only on the falling edge, and returns the strobes to zero before the next access. The random addresses carry arbitrary upper bytes. Their low bytes are drawn from the boundaries of every decoded range, so each edge of each window is exercised from both sides.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_CON,
      RGN_CAS,
      RGN_DSK,
      RGN_TRAP,
      RGN_GPP
   } rgn_e;

   localparam int NUM_DEV = 3;

   // device index order: 0 console, 1 cassette, 2 disk slot
   function automatic logic [7:0] dev_first(input int idx);
      case (idx)
         0:       return 8'hE8;
         1:       return 8'hF8;
         default: return 8'h78;
      endcase
   endfunction

   function automatic logic [7:0] dev_last(input int idx);
      case (idx)
         0:       return 8'hEF;
         1:       return 8'hF9;
         default: return 8'h7B;
      endcase
   endfunction

   localparam logic [7:0] GPP_PORT = 8'hF2;

   function automatic logic is_trap_port(input logic [7:0] p);
      return (p == 8'hF0) || (p == 8'hF1) || (p == 8'hFA) || (p == 8'hFB);
   endfunction

   function automatic logic [1:0] view_code(input logic rom_en, input logic wp);
      if (!rom_en)
         return 2'd2;
      else if (wp)
         return 2'd0;
      else
         return 2'd1;
   endfunction

endpackage

// File: rtl/iodec_addr_map.sv
module iodec_addr_map
   import iodec_pkg::*;
(
   input  logic [7:0]         port_lo,
   input  logic               acc_rd,
   input  logic               acc_wr,
   output logic [NUM_DEV-1:0] dev_sel,
   output logic               trap_hit,
   output logic               gpp_hit,
   output rgn_e               region
);

   logic [NUM_DEV-1:0] in_win;

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_win
      localparam logic [7:0] LO = dev_first(g);
      localparam logic [7:0] HI = dev_last(g);
      assign in_win[g]  = (port_lo >= LO) && (port_lo <= HI);
      assign dev_sel[g] = (acc_rd | acc_wr) & in_win[g];
   end

   logic any_acc;
   assign any_acc  = acc_rd | acc_wr;
   assign trap_hit = any_acc & is_trap_port(port_lo);
   assign gpp_hit  = any_acc & (port_lo == GPP_PORT);

   always_comb begin
      region = RGN_NONE;
      if (in_win[0])
         region = RGN_CON;
      else if (in_win[1])
         region = RGN_CAS;
      else if (in_win[2])
         region = RGN_DSK;
      else if (is_trap_port(port_lo))
         region = RGN_TRAP;
      else if (port_lo == GPP_PORT)
         region = RGN_GPP;
   end

endmodule

// File: rtl/iodec_nmi_stretch.sv
module iodec_nmi_stretch #(
   parameter int NMI_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);

   localparam int CW = $clog2(NMI_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(NMI_CYCLES);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= '0;
      else if (trig)
         remain_q <= LOAD;
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   assign pulse = (remain_q != '0);

endmodule

// File: rtl/iodec_tick_irq.sv
module iodec_tick_irq #(
   parameter int TICK_CYCLES = 400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ack,
   output logic irq
);

   localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CW-1:0] WRAP = CW'(TICK_CYCLES - 1);

   logic [CW-1:0] div_q;
   logic          tick;
   logic          irq_q;

   assign tick = (div_q == WRAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (tick)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (tick && enable)
         irq_q <= 1'b1;
      else if (ack)
         irq_q <= 1'b0;
   end

   assign irq = irq_q;

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
   import iodec_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int NMI_CYCLES  = 400,
   parameter int TICK_CYCLES = 400000,
   parameter int ROM_EN_BIT  = 5,
   parameter int WP_BIT      = 3,
   parameter int TMR_EN_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] sw_bank,
   input  logic [DATA_W-1:0] con_rdata,
   input  logic [DATA_W-1:0] cas_rdata,
   input  logic [DATA_W-1:0] dsk_rdata,
   input  logic              tmr_ack,
   output logic              con_cs,
   output logic              cas_cs,
   output logic              dsk_cs,
   output logic [DATA_W-1:0] io_rdata,
   output logic              nmi_out,
   output logic              tmr_irq,
   output logic [1:0]        mem_view,
   output logic [1:0]        exp_bits
);

   localparam logic [DATA_W-1:0] LATCH_RST =
      DATA_W'((1 << ROM_EN_BIT) | (1 << TMR_EN_BIT));
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   if (DATA_W != 8) begin : g_bad_width
      $error("io_port_decoder: DATA_W must be 8");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("io_port_decoder: ADDR_W must be at least 8");
   end
   if (ROM_EN_BIT > 5 || WP_BIT > 5 || TMR_EN_BIT > 5 ||
       ROM_EN_BIT < 0 || WP_BIT < 0 || TMR_EN_BIT < 0) begin : g_bad_bitpos
      $error("io_port_decoder: control bits must lie in 5:0");
   end
   if (ROM_EN_BIT == WP_BIT || ROM_EN_BIT == TMR_EN_BIT ||
       WP_BIT == TMR_EN_BIT) begin : g_bad_overlap
      $error("io_port_decoder: control bits must be distinct");
   end
   if (NMI_CYCLES < 1 || TICK_CYCLES < 2) begin : g_bad_count
      $error("io_port_decoder: pulse and tick counts too small");
   end

   logic [7:0]         port_lo;
   logic [NUM_DEV-1:0] dev_sel;
   logic               trap_hit;
   logic               gpp_hit;
   rgn_e               region;

   assign port_lo = io_addr[7:0];

   iodec_addr_map u_map (
      .port_lo (port_lo),
      .acc_rd  (io_rd),
      .acc_wr  (io_wr),
      .dev_sel (dev_sel),
      .trap_hit(trap_hit),
      .gpp_hit (gpp_hit),
      .region  (region)
   );

   assign con_cs = dev_sel[0];
   assign cas_cs = dev_sel[1];
   assign dsk_cs = dev_sel[2];

   // general purpose latch
   logic [DATA_W-1:0] gpp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gpp_q <= LATCH_RST;
      else if (gpp_hit && io_wr)
         gpp_q <= io_wdata;
   end

   logic rom_en_w;
   logic wp_w;
   logic tmr_en_w;

   assign rom_en_w = gpp_q[ROM_EN_BIT];
   assign wp_w     = gpp_q[WP_BIT];
   assign tmr_en_w = gpp_q[TMR_EN_BIT];
   assign mem_view = view_code(rom_en_w, wp_w);
   assign exp_bits = gpp_q[7:6];

   // read data steering
   always_comb begin
      case (region)
         RGN_CON:  io_rdata = con_rdata;
         RGN_CAS:  io_rdata = cas_rdata;
         RGN_DSK:  io_rdata = dsk_rdata;
         RGN_TRAP: io_rdata = '0;
         RGN_GPP:  io_rdata = sw_bank;
         default:  io_rdata = ALL_ONES;
      endcase
   end

   iodec_nmi_stretch #(.NMI_CYCLES(NMI_CYCLES)) u_nmi (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trap_hit),
      .pulse(nmi_out)
   );

   iodec_tick_irq #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(tmr_en_w),
      .ack   (tmr_ack),
      .irq   (tmr_irq)
   );

endmodule

// File: rtl/iodec_chk.sv
module iodec_chk #(
   parameter int NMI_CYCLES = 400
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] port_lo,
   input logic       io_rd,
   input logic       io_wr,
   input logic [7:0] io_wdata,
   input logic       con_cs,
   input logic       cas_cs,
   input logic       dsk_cs,
   input logic [7:0] io_rdata,
   input logic       nmi_out,
   input logic       tmr_irq,
   input logic       tmr_ack,
   input logic       tmr_en,
   input logic [1:0] mem_view,
   input logic [1:0] exp_bits
);

   localparam int SW = $clog2(NMI_CYCLES + 1);

   logic trap_acc;
   logic gpp_port;
   assign trap_acc = (io_rd | io_wr) &&
                     (port_lo == 8'hF0 || port_lo == 8'hF1 ||
                      port_lo == 8'hFA || port_lo == 8'hFB);
   assign gpp_port = (port_lo == 8'hF2);

   logic [SW-1:0] since_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (trap_acc) begin
         since_q <= '0;
         seen_q  <= 1'b1;
      end else if (since_q != SW'(NMI_CYCLES)) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R3
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({con_cs, cas_cs, dsk_cs}));

   // R2
   unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !con_cs && !cas_cs && !dsk_cs && !trap_acc && !gpp_port)
      |-> (io_rdata == 8'hFF));

   // R4
   nmi_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_acc |=> nmi_out);

   // R4
   nmi_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_out |-> (seen_q && since_q < SW'(NMI_CYCLES)));

   // R5
   nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && since_q < SW'(NMI_CYCLES)) |-> nmi_out);

   // R6
   exp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && gpp_port) |=> (exp_bits == $past(io_wdata[7:6])));

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_irq && !tmr_ack) |=> tmr_irq);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_irq) |-> $past(tmr_en));

   // R10
   view_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_view != 2'd3);

endmodule

bind io_port_decoder iodec_chk #(.NMI_CYCLES(NMI_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .port_lo  (io_addr[7:0]),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .io_wdata (io_wdata),
   .con_cs   (con_cs),
   .cas_cs   (cas_cs),
   .dsk_cs   (dsk_cs),
   .io_rdata (io_rdata),
   .nmi_out  (nmi_out),
   .tmr_irq  (tmr_irq),
   .tmr_ack  (tmr_ack),
   .tmr_en   (tmr_en_w),
   .mem_view (mem_view),
   .exp_bits (exp_bits)
);

// File: tb/io_port_decoder_tb_top.sv
`timescale 1ns/1ps
module io_port_decoder_tb_top;

   localparam int NMI_N  = 8;
   localparam int TICK_N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  sw_bank = 8'h5A;
   logic [7:0]  con_rdata = '0;
   logic [7:0]  cas_rdata = '0;
   logic [7:0]  dsk_rdata = '0;
   logic        tmr_ack = 1'b0;
   logic        con_cs, cas_cs, dsk_cs, nmi_out, tmr_irq;
   logic [7:0]  io_rdata;
   logic [1:0]  mem_view, exp_bits;

   int unsigned nvec = 0;
   int unsigned nerr = 0;
   longint      cyc = 0;
   logic [7:0]  m_latch;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   io_port_decoder #(
      .NMI_CYCLES (NMI_N),
      .TICK_CYCLES(TICK_N)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .sw_bank(sw_bank), .con_rdata(con_rdata),
      .cas_rdata(cas_rdata), .dsk_rdata(dsk_rdata), .tmr_ack(tmr_ack),
      .con_cs(con_cs), .cas_cs(cas_cs), .dsk_cs(dsk_cs), .io_rdata(io_rdata),
      .nmi_out(nmi_out), .tmr_irq(tmr_irq), .mem_view(mem_view), .exp_bits(exp_bits)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected chip-select vector {dsk,cas,con} for a low byte (R3)
   function automatic logic [2:0] exp_cs(input logic [7:0] p);
      if (p >= 8'hE8 && p <= 8'hEF) return 3'b001;
      if (p == 8'hF8 || p == 8'hF9) return 3'b010;
      if (p >= 8'h78 && p <= 8'h7B) return 3'b100;
      return 3'b000;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [7:0] p, input logic [7:0] c,
                                         input logic [7:0] k, input logic [7:0] d,
                                         input logic [7:0] s);
      case (exp_cs(p))
         3'b001: return c;
         3'b010: return k;
         3'b100: return d;
         default: ;
      endcase
      if (p == 8'hF0 || p == 8'hF1 || p == 8'hFA || p == 8'hFB) return 8'h00;
      if (p == 8'hF2) return s;
      return 8'hFF;
   endfunction

   function automatic logic [1:0] exp_view(input logic [7:0] l);
      if (!l[5]) return 2'd2;
      return l[3] ? 2'd0 : 2'd1;
   endfunction

   function automatic logic [7:0] pick_port(input int unsigned r);
      case (r % 20)
         0: return 8'h77;  1: return 8'h78;  2: return 8'h7B;  3: return 8'h7C;
         4: return 8'hE7;  5: return 8'hE8;  6: return 8'hEF;  7: return 8'hF0;
         8: return 8'hF1;  9: return 8'hF2; 10: return 8'hF3; 11: return 8'hF7;
        12: return 8'hF8; 13: return 8'hF9; 14: return 8'hFA; 15: return 8'hFB;
        16: return 8'hFC; 17: return 8'hEB;
         default: return 8'($urandom);
      endcase
   endfunction

   task automatic do_io(input logic rd, input logic wr, input logic [15:0] a,
                        input logic [7:0] wd, input string req);
      logic [7:0] p;
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd;
      con_rdata = 8'($urandom); cas_rdata = 8'($urandom); dsk_rdata = 8'($urandom);
      sw_bank = 8'($urandom);
      p = a[7:0];
      #1;
      chk({req, " R1 R3 cs"}, {29'd0, dsk_cs, cas_cs, con_cs},
          (rd | wr) ? {29'd0, exp_cs(p)} : 32'd0);
      if (rd)
         chk({req, " R2 R4 R6 rdata"}, {24'd0, io_rdata},
             {24'd0, exp_rd(p, con_rdata, cas_rdata, dsk_rdata, sw_bank)});
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0;
      if (wr && p == 8'hF2) m_latch = wd;
      chk({req, " R10 view"}, {30'd0, mem_view}, {30'd0, exp_view(m_latch)});
      chk({req, " R6 exp"}, {30'd0, exp_bits}, {30'd0, m_latch[7:6]});
   endtask

   task automatic count_nmi(output int n);
      n = 0;
      while (nmi_out && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wait_irq(output longint t);
      int k;
      k = 0;
      while (!tmr_irq && k < 4 * TICK_N) begin
         @(negedge clk);
         k++;
      end
      t = cyc;
   endtask

   initial begin
      int n;
      longint t0, t1;
      logic bad;
      void'($urandom(32'd20240107));
      m_latch = 8'h22;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 nmi", {31'd0, nmi_out}, 0);
      chk("R9 irq", {31'd0, tmr_irq}, 0);
      chk("R9 view", {30'd0, mem_view}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 exp", {30'd0, exp_bits}, 0);
      chk("R9 view after release", {30'd0, mem_view}, 1);
      chk("R9 nmi after release", {31'd0, nmi_out}, 0);

      // R1 directed: upper byte ignored
      do_io(1, 0, 16'hABE9, 8'h00, "R1 upper bits");
      do_io(1, 0, 16'h3455, 8'h00, "R2 unmapped");

      // R4 pulse width and trap read value
      repeat (NMI_N + 2) @(negedge clk);
      do_io(1, 0, 16'h00F1, 8'h00, "R4 trap read");
      count_nmi(n);
      chk("R4 pulse width", n, NMI_N + 0 - 1 + 1);
      do_io(0, 1, 16'h12FA, 8'h77, "R4 trap write");
      count_nmi(n);
      chk("R4 pulse width write", n, NMI_N);

      // R5 restart
      do_io(0, 1, 16'h00F0, 8'h00, "R5 first");
      repeat (3) @(negedge clk);
      do_io(1, 0, 16'h00FB, 8'h00, "R5 second");
      count_nmi(n);
      chk("R5 restart width", n, NMI_N);

      // R10 view encodings
      do_io(0, 1, 16'h00F2, 8'h20, "R10 rom no-wp");
      do_io(0, 1, 16'h00F2, 8'h28, "R10 rom wp");
      do_io(0, 1, 16'h00F2, 8'h00, "R10 rom off");
      do_io(0, 1, 16'h00F2, 8'h08, "R10 rom off wp");
      do_io(0, 1, 16'h00F2, 8'hC0, "R6 exp bits");

      // R8 timer disabled
      do_io(0, 1, 16'h00F2, 8'h20, "R8 disable");
      @(negedge clk); tmr_ack = 1'b1; @(negedge clk); tmr_ack = 1'b0;
      bad = 1'b0;
      for (int i = 0; i < 3 * TICK_N; i++) begin
         @(negedge clk);
         if (tmr_irq) bad = 1'b1;
      end
      chk("R8 no irq while disabled", {31'd0, bad}, 0);

      // R7 period and hold
      do_io(0, 1, 16'h00F2, 8'h22, "R7 enable");
      wait_irq(t0);
      chk("R7 first irq", {31'd0, tmr_irq}, 1);
      tmr_ack = 1'b1; @(negedge clk); tmr_ack = 1'b0;
      chk("R7 ack clears", {31'd0, tmr_irq}, 0);
      wait_irq(t1);
      chk("R7 period", 32'(t1 - t0), TICK_N);
      bad = 1'b0;
      for (int i = 0; i < 2 * TICK_N; i++) begin
         @(negedge clk);
         if (!tmr_irq) bad = 1'b1;
      end
      chk("R7 held until ack", {31'd0, bad}, 0);
      tmr_ack = 1'b1; @(negedge clk); tmr_ack = 1'b0;
      chk("R7 ack clears again", {31'd0, tmr_irq}, 0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned k;
         logic [15:0] a;
         k = $urandom % 3;
         a = {8'($urandom), pick_port($urandom)};
         do_io(k == 0, k == 1, a, 8'($urandom), "rand");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      nvec++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule